// File: doc/BRIEF.md
# User Interrupt Controller Register Block

This block gathers up to sixteen level-type interrupt sources from user logic. It decides when each source should raise an interrupt event. A rising edge on an enabled source raises an event. So does enabling a source that is already high. Events are latched and offered one at a time on a valid/acknowledge output. Each offer carries the source index, a programmable 5-bit vector number and a 2-bit legacy line index taken from that vector.

Software reaches the block through a simple 32-bit register port with a byte address. The write is a single-cycle strobe and the read data is combinational. The register space holds:
- an identifier word;
- one enable mask, reached through a plain read/write alias, a write-one-to-set alias and a write-one-to-clear alias;
- two read-only views of source state, request and pending;
- four words of per-source vector numbers.

Top module: `uirq_regblk`

## Requirements
- R1: Offset 0x00 reads {12'h1FC, 4'h2, 8'h00, VERSION}, with VERSION defaulting to 8'h04. Writes to it have no effect.
- R2: The enable mask (bit i belongs to source i) is written by value at 0x04, OR-ed with the write data at 0x08 and AND-ed with the inverted write data at 0x0C. All three offsets read the mask, and bits at and above NUM_SRC read zero.
- R3: After reset the mask is all ones when MASK_RST_ONES is 1 and all zeros when it is 0.
- R4: A source whose mask bit is 0 never raises an event and never sets pending. A rising edge on an enabled source raises an event, and irq_valid_o is high two clock edges after the source input rises.
- R5: A mask bit going from 0 to 1 while its sampled source is high raises an event for that source.
- R6: Offset 0x40 reads the registered source sample AND-ed with the mask.
- R7: At offset 0x48, bit i is set when source i raises an event. It stays set until the sampled source is low. Acknowledge and register writes do not clear it.
- R8: Offset 0x80+4k holds the vector fields of sources 4k..4k+3, at bits 4:0, 12:8, 20:16 and 28:24 in that order. The fields are read/write and the field of source i resets to i. All other bits read zero.
- R9: While irq_valid_o is high, irq_src_o names the offered source. irq_vec_o is that source's vector field, and irq_line_o is the vector's two low bits (0=A, 1=B, 2=C, 3=D).
- R10: Of the latched events, the lowest-numbered source is offered. irq_valid_o stays high until acknowledged, and irq_ack_i retires the offered event.
- R11: A new trigger on a source whose event is still latched merges into it, so one acknowledge retires both.
- R12: Clearing a mask bit discards that source's latched event at once, and the next event is offered.
- R13: Reserved and unmapped offsets read zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Level interrupt sources |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| irq_valid_o | output | 1 | An event is offered |
| irq_ack_i | input | 1 | Retires the offered event |
| irq_src_o | output | SELW | Index of the offered source |
| irq_vec_o | output | 5 | Vector number of the offered source |
| irq_line_o | output | 2 | Legacy line index (vector bits 1:0) |

## Verification
Every one of the sixteen sources is raised alone with only its own mask bit set. This separates a wrong index, vector or line lookup for any single position. Scattered multi-source patterns raised together are drained one acknowledge at a time, which shows whether the offer order follows the lowest index. Sources held high while masked, then enabled through the set alias, tell the enable-time trigger apart from the edge trigger. Dropping and re-raising a source with its event latched, and clearing a mask bit under a latched event, tell merging apart from discarding. Mask alias patterns and vector write patterns are swept, and the bench recomputes each readback arithmetically.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam logic [7:0] A_IDENT    = 8'h00;
  localparam logic [7:0] A_MASK_RW  = 8'h04;
  localparam logic [7:0] A_MASK_SET = 8'h08;
  localparam logic [7:0] A_MASK_CLR = 8'h0C;
  localparam logic [7:0] A_REQ      = 8'h40;
  localparam logic [7:0] A_PEND     = 8'h48;
  localparam logic [7:0] A_VEC_BASE = 8'h80;
  localparam int         VEC_W      = 5;
  localparam int         MAX_SRC    = 16;
  localparam logic [11:0] ID_HIGH   = 12'h1FC;
  localparam logic [3:0]  ID_KIND   = 4'h2;
endpackage

// File: rtl/uirq_mask_regs.sv
module uirq_mask_regs #(
  parameter int N             = 16,
  parameter bit MASK_RST_ONES = 1'b0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [7:0]                 addr,
  input  logic [31:0]                wdata,
  output logic [N-1:0]               mask_q,
  output logic [N*uirq_pkg::VEC_W-1:0] vec_flat
);
  import uirq_pkg::*;
  localparam logic [N-1:0] MASK_RST = MASK_RST_ONES ? {N{1'b1}} : {N{1'b0}};

  logic [N-1:0] mask_d;

  always_comb begin
    mask_d = mask_q;
    if (wr_en) begin
      case (addr)
        A_MASK_RW:  mask_d = wdata[N-1:0];
        A_MASK_SET: mask_d = mask_q | wdata[N-1:0];
        A_MASK_CLR: mask_d = mask_q & ~wdata[N-1:0];
        default:    mask_d = mask_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= MASK_RST;
    else        mask_q <= mask_d;
  end

  for (genvar i = 0; i < N; i++) begin : g_vec
    localparam logic [7:0] REG_A = A_VEC_BASE + 8'(4 * (i / 4));
    localparam int         LSB   = 8 * (i % 4);
    logic [VEC_W-1:0] vq, vd;
    logic             hit;

    assign hit = wr_en && (addr == REG_A);

    always_comb begin
      vd = vq;
      if (hit) vd = wdata[LSB +: VEC_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vq <= VEC_W'(i);
      else        vq <= vd;
    end

    assign vec_flat[i*VEC_W +: VEC_W] = vq;
  end
endmodule

// File: rtl/uirq_trigger.sv
module uirq_trigger #(
  parameter int N             = 16,
  parameter bit MASK_RST_ONES = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src_i,
  input  logic [N-1:0] mask_q,
  input  logic [N-1:0] retire,
  output logic [N-1:0] src_q,
  output logic [N-1:0] evt_vis,
  output logic [N-1:0] pend_q
);
  localparam logic [N-1:0] MASK_RST = MASK_RST_ONES ? {N{1'b1}} : {N{1'b0}};

  logic [N-1:0] src_prev, mask_prev, evt_q;
  logic [N-1:0] trig, evt_d, pend_d;

  always_comb begin
    trig    = mask_q & src_q & (~src_prev | ~mask_prev);
    evt_d   = mask_q & ((evt_q & ~retire) | trig);
    pend_d  = (pend_q | trig) & src_q;
    evt_vis = evt_q & mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q     <= '0;
      src_prev  <= '0;
      mask_prev <= MASK_RST;
      evt_q     <= '0;
      pend_q    <= '0;
    end else begin
      src_q     <= src_i;
      src_prev  <= src_q;
      mask_prev <= mask_q;
      evt_q     <= evt_d;
      pend_q    <= pend_d;
    end
  end
endmodule

// File: rtl/uirq_arbiter.sv
module uirq_arbiter #(
  parameter int N    = 16,
  parameter int SELW = 4
) (
  input  logic [N-1:0]                 evt_vis,
  input  logic [N*uirq_pkg::VEC_W-1:0] vec_flat,
  input  logic                         ack,
  output logic                         valid,
  output logic [SELW-1:0]              sel,
  output logic [uirq_pkg::VEC_W-1:0]   vec,
  output logic [N-1:0]                 retire
);
  import uirq_pkg::*;

  always_comb begin
    sel = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (evt_vis[i]) sel = SELW'(i);
    end
    valid  = |evt_vis;
    vec    = vec_flat[int'(sel)*VEC_W +: VEC_W];
    retire = '0;
    if (valid && ack) retire[sel] = 1'b1;
  end
endmodule

// File: rtl/uirq_regblk.sv
module uirq_regblk #(
  parameter int         NUM_SRC       = 16,
  parameter bit         MASK_RST_ONES = 1'b0,
  parameter logic [7:0] VERSION       = 8'h04,
  localparam int        SELW          = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               reg_wr_i,
  input  logic [7:0]         reg_addr_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [31:0]        reg_rdata_o,
  output logic               irq_valid_o,
  input  logic               irq_ack_i,
  output logic [SELW-1:0]    irq_src_o,
  output logic [4:0]         irq_vec_o,
  output logic [1:0]         irq_line_o
);
  import uirq_pkg::*;

  logic [NUM_SRC-1:0]         mask_q, src_q, evt_vis, pend_q, retire;
  logic [NUM_SRC*VEC_W-1:0]   vec_flat;

  uirq_mask_regs #(.N(NUM_SRC), .MASK_RST_ONES(MASK_RST_ONES)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_i), .addr(reg_addr_i),
    .wdata(reg_wdata_i), .mask_q(mask_q), .vec_flat(vec_flat)
  );

  uirq_trigger #(.N(NUM_SRC), .MASK_RST_ONES(MASK_RST_ONES)) trig_i (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .mask_q(mask_q),
    .retire(retire), .src_q(src_q), .evt_vis(evt_vis), .pend_q(pend_q)
  );

  uirq_arbiter #(.N(NUM_SRC), .SELW(SELW)) arb_i (
    .evt_vis(evt_vis), .vec_flat(vec_flat), .ack(irq_ack_i),
    .valid(irq_valid_o), .sel(irq_src_o), .vec(irq_vec_o), .retire(retire)
  );

  assign irq_line_o = irq_vec_o[1:0];

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_IDENT:                          reg_rdata_o = {ID_HIGH, ID_KIND, 8'h00, VERSION};
      A_MASK_RW, A_MASK_SET, A_MASK_CLR: reg_rdata_o[NUM_SRC-1:0] = mask_q;
      A_REQ:                            reg_rdata_o[NUM_SRC-1:0] = src_q & mask_q;
      A_PEND:                           reg_rdata_o[NUM_SRC-1:0] = pend_q;
      default: begin
        for (int k = 0; k < MAX_SRC / 4; k++) begin
          if (reg_addr_i == A_VEC_BASE + 8'(4 * k)) begin
            for (int j = 0; j < 4; j++) begin
              if (4 * k + j < NUM_SRC)
                reg_rdata_o[8*j +: VEC_W] = vec_flat[(4*k+j)*VEC_W +: VEC_W];
            end
          end
        end
      end
    endcase
  end
endmodule

// File: rtl/uirq_regblk_chk.sv
module uirq_regblk_chk #(
  parameter int N    = 16,
  parameter int SELW = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_wr_i,
  input logic [7:0]      reg_addr_i,
  input logic [31:0]     reg_rdata_o,
  input logic            irq_valid_o,
  input logic            irq_ack_i,
  input logic [SELW-1:0] irq_src_o,
  input logic [N-1:0]    mask_q,
  input logic [N-1:0]    src_q,
  input logic [N-1:0]    evt_vis,
  input logic [N-1:0]    pend_q
);
  // R12, R4: an offered source always has its mask bit set
  a_r12_offer_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid_o |-> mask_q[irq_src_o]);

  // R10: no lower-numbered latched event is passed over
  a_r10_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid_o |-> ((evt_vis & ((N'(1) << irq_src_o) - N'(1))) == '0));

  // R10: an offer is withdrawn only by acknowledge or a register write
  a_r10_valid_held: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid_o && !irq_ack_i && !reg_wr_i) |=> irq_valid_o);

  // R7: pending never survives a low source sample
  a_r7_pend_needs_src: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(src_q)) == '0));

  // R6: the request view follows sample and mask
  a_r6_req_view: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr_i == 8'h40) |-> (reg_rdata_o[N-1:0] == (src_q & mask_q)));

  // R13: a reserved offset reads zero
  a_r13_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr_i == 8'h44) |-> (reg_rdata_o == 32'h0));
endmodule

bind uirq_regblk uirq_regblk_chk #(.N(NUM_SRC), .SELW(SELW)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
  .reg_rdata_o(reg_rdata_o), .irq_valid_o(irq_valid_o), .irq_ack_i(irq_ack_i),
  .irq_src_o(irq_src_o), .mask_q(mask_q), .src_q(src_q), .evt_vis(evt_vis),
  .pend_q(pend_q)
);

// File: tb/uirq_regblk_tb_top.sv
module uirq_regblk_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] src;
  logic        wr, ack;
  logic [7:0]  addr;
  logic [31:0] wdata, rdata;
  logic        valid;
  logic [3:0]  isrc;
  logic [4:0]  ivec;
  logic [1:0]  iline;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  uirq_regblk dut_i (
    .clk(clk), .rst_n(rst_n), .src_i(src), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_valid_o(valid),
    .irq_ack_i(ack), .irq_src_o(isrc), .irq_vec_o(ivec), .irq_line_o(iline)
  );

  function automatic logic [4:0] vexp(int i);
    return 5'((i * 7 + 3) & 31);
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wreg(logic [7:0] a, logic [31:0] d);
    addr = a; wdata = d; wr = 1'b1;
    tick(1);
    wr = 1'b0;
  endtask

  task automatic rreg(logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic pulse_ack();
    ack = 1'b1;
    tick(1);
    ack = 1'b0;
  endtask

  initial begin
    #2_000_000;
    tests++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] d, p, q, r, m, rem;
    logic [7:0] rsv [8];
    rsv = '{8'h10, 8'h14, 8'h18, 8'h44, 8'h4C, 8'hA0, 8'hA4, 8'hFC};
    rst_n = 1'b0; src = '0; wr = 1'b0; ack = 1'b0; addr = '0; wdata = '0;
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R1 identifier and write immunity
    rreg(8'h00, d); chk("R1 ident", d, 32'h1FC2_0004);
    wreg(8'h00, 32'hFFFF_FFFF);
    rreg(8'h00, d); chk("R1 ident after write", d, 32'h1FC2_0004);
    // R3 mask reset value (zeros mode)
    rreg(8'h04, d); chk("R3 mask reset", d, 32'h0);
    chk("R4 no offer after reset", {31'h0, valid}, 32'h0);
    // R8 vector reset values
    for (int k = 0; k < 4; k++) begin
      rreg(8'(8'h80 + 4 * k), d);
      chk("R8 vector reset", d, {3'b0, 5'(4*k+3), 3'b0, 5'(4*k+2), 3'b0, 5'(4*k+1), 3'b0, 5'(4*k)});
    end
    // R13 reserved reads and writes
    for (int k = 0; k < 8; k++) begin
      wreg(rsv[k], 32'hFFFF_FFFF);
      rreg(rsv[k], d); chk("R13 reserved reads zero", d, 32'h0);
    end
    rreg(8'h04, d); chk("R13 reserved write left mask", d, 32'h0);
    // R2 mask aliases
    for (int k = 0; k < 8; k++) begin
      p = 32'h0001_3579 * (k + 1);
      q = 32'h0000_0421 << k;
      r = 32'h0000_8181 >> k;
      wreg(8'h04, p);
      rreg(8'h04, d); chk("R2 mask rw", d, p & 32'hFFFF);
      wreg(8'h08, q);
      rreg(8'h08, d); chk("R2 mask w1s", d, (p | q) & 32'hFFFF);
      wreg(8'h0C, r);
      rreg(8'h0C, d); chk("R2 mask w1c", d, (p | q) & ~r & 32'hFFFF);
    end
    wreg(8'h04, 32'h0);
    // R8 vector write masking and programming
    wreg(8'h84, 32'hFFFF_FFFF);
    rreg(8'h84, d); chk("R8 field width", d, 32'h1F1F_1F1F);
    for (int k = 0; k < 4; k++)
      wreg(8'(8'h80 + 4 * k), {3'b111, vexp(4*k+3), 3'b111, vexp(4*k+2), 3'b111, vexp(4*k+1), 3'b111, vexp(4*k)});
    for (int k = 0; k < 4; k++) begin
      rreg(8'(8'h80 + 4 * k), d);
      chk("R8 vector readback", d, {3'b0, vexp(4*k+3), 3'b0, vexp(4*k+2), 3'b0, vexp(4*k+1), 3'b0, vexp(4*k)});
    end
    // R4 R6 R7 R9 single-source sweep
    for (int i = 0; i < 16; i++) begin
      wreg(8'h04, 32'h1 << i);
      src = 16'(1 << i);
      tick(2);
      chk("R4 edge offer", {31'h0, valid}, 32'h1);
      chk("R9 source index", {28'h0, isrc}, 32'(i));
      chk("R9 vector", {27'h0, ivec}, {27'h0, vexp(i)});
      chk("R9 legacy line", {30'h0, iline}, {30'h0, vexp(i) & 5'h3});
      rreg(8'h40, d); chk("R6 request view", d, 32'h1 << i);
      pulse_ack();
      chk("R10 ack retires", {31'h0, valid}, 32'h0);
      rreg(8'h48, d); chk("R7 pending after ack", d, 32'h1 << i);
      src = '0;
      tick(2);
      rreg(8'h48, d); chk("R7 pending clears on low", d, 32'h0);
    end
    // R4 masked sources stay silent
    wreg(8'h04, 32'h0);
    src = 16'h00F0;
    tick(3);
    chk("R4 masked silent", {31'h0, valid}, 32'h0);
    rreg(8'h40, d); chk("R6 masked request", d, 32'h0);
    rreg(8'h48, d); chk("R4 masked no pending", d, 32'h0);
    // R5 enable while high
    wreg(8'h08, 32'h20);
    tick(1);
    chk("R5 enable trigger", {28'h0, isrc, 3'b0, valid}, {28'h5, 4'h1});
    pulse_ack();
    // R12 discard on mask clear
    wreg(8'h08, 32'h50);
    tick(1);
    chk("R10 lower first", {28'h0, isrc, 3'b0, valid}, {28'h4, 4'h1});
    wreg(8'h0C, 32'h10);
    chk("R12 discarded event", {28'h0, isrc, 3'b0, valid}, {28'h6, 4'h1});
    pulse_ack();
    chk("R12 nothing left", {31'h0, valid}, 32'h0);
    wreg(8'h08, 32'h10);
    tick(1);
    chk("R5 re-enable trigger", {28'h0, isrc, 3'b0, valid}, {28'h4, 4'h1});
    pulse_ack();
    // R10 priority drain of several patterns
    src = '0;
    wreg(8'h04, 32'hFFFF);
    tick(2);
    for (int t = 0; t < 4; t++) begin
      m = (32'hA581 * (t + 3)) & 32'hFFFF;
      src = m[15:0];
      tick(2);
      rem = m;
      for (int b = 0; b < 16; b++) begin
        if (rem[b]) begin
          chk("R10 drain order", {28'h0, isrc, 3'b0, valid}, {28'(b), 4'h1});
          pulse_ack();
          rem[b] = 1'b0;
        end
      end
      chk("R10 drained", {31'h0, valid}, 32'h0);
      src = '0;
      tick(2);
    end
    // R11 merge of retrigger
    src = 16'h0200;
    tick(2);
    src = '0;
    tick(1);
    src = 16'h0200;
    tick(2);
    chk("R11 merged offer", {28'h0, isrc, 3'b0, valid}, {28'h9, 4'h1});
    wreg(8'h48, 32'h0);
    rreg(8'h48, d); chk("R7 pending write ignored", d, 32'h0200);
    pulse_ack();
    chk("R11 one ack clears", {31'h0, valid}, 32'h0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule